// File: doc/BRIEF.md
# Block Descriptor Fetch Predictor

This stage produces block-level control flow for a decoupled processor front end. The fetch address never names an instruction. It always names a 32-bit block descriptor, which tells the stage how the basic block ends, where the block's instructions start and how many there are. Each cycle the stage looks up the current descriptor address in a small direct-mapped descriptor cache. It decodes the block's terminating kind and picks the next descriptor address. It then pushes the descriptor, the full instruction address and the chosen successor into an eight-entry block queue. An instruction fetch unit drains that queue later.

Targets relative to the fetch address come straight from the descriptor. Only conditional blocks consult the two-bit direction counters, and a hint in the descriptor can override those counters. Calls and returns use a small return stack. A block that ends in an indirect jump waits for the back end to supply its target. A cache miss raises a refill request, and the stage idles until the descriptor word arrives. The absolute instruction address and the relative target are computed once, at refill time, and stored with the line. A redirect from the back end empties the queue and restarts lookup at the corrected address.

Top module: `desc_fetch_stage`

## Requirements
- R1: After reset the queue is empty (`qValid` low) and `fetchAddr` equals 0.
- R2: Descriptor layout: kind in bits 31:28, length in 27:24, hint in 23:22, signed 10-bit offset in 21:12 counted in descriptors, and instruction word index in 11:0. Kind codes: 0 fall-through, 1 jump, 2 indirect jump, 3 forward branch, 4 backward branch, 5 call, 6 return; codes 7 to 15 behave as fall-through. A fall-through block's successor is its address plus 1. A jump's or call's successor is its address plus the offset.
- R3: A call pushes its own address plus 1 onto a 4-entry return stack. A return takes its successor from the top of that stack and pops it.
- R4: For a conditional block, hint 2 forces taken and hint 1 forces not-taken. Hints 0 and 3 defer to a 2-bit counter selected by the low 4 address bits. Counters reset to 1 (weakly not-taken) and are trained through `updValid`/`updAddr`/`updTaken`; a counter value of 2 or more means taken. A taken branch goes to address plus offset, a not-taken one to address plus 1. `qTaken` reports the chosen direction, and it is 0 for every other kind.
- R5: Fall-through and jump blocks never use the direction counters: their successor is the same whatever the counter at their index holds.
- R6: On a hit, the stage pushes one entry carrying the descriptor word unchanged, the instruction address {page base, word index, 2'b00} and the successor. Lookup moves to the successor in the next cycle. The page base in the entry is the one sampled when the line was refilled.
- R7: On a miss, `refillReq` is held with `refillAddr` equal to the missing address until `refillValid` arrives. Nothing is pushed meanwhile.
- R8: An indirect-jump block is neither pushed nor passed until `jrValid` is high. Its successor is then `jrTarget`.
- R9: The queue holds 8 entries in order. When it is full, lookup holds its address and loses no descriptor.
- R10: `redirectValid` empties the queue, restarts lookup at `redirectAddr` and cancels a pending refill. In the same cycle it wins over a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pageBase | input | 18 | Upper instruction-address bits |
| redirectValid | input | 1 | Misprediction restart strobe |
| redirectAddr | input | 16 | Corrected descriptor address |
| jrValid | input | 1 | Indirect-jump target available |
| jrTarget | input | 16 | Indirect-jump descriptor target |
| updValid | input | 1 | Direction counter training strobe |
| updAddr | input | 16 | Descriptor address of the trained branch |
| updTaken | input | 1 | Resolved direction |
| refillReq | output | 1 | Descriptor refill request |
| refillAddr | output | 16 | Address to refill |
| refillValid | input | 1 | Refill word valid |
| refillData | input | 32 | Refilled descriptor word |
| qValid | output | 1 | Queue head valid |
| qReady | input | 1 | Consumer pops the head |
| qDesc | output | 32 | Head descriptor word |
| qInstAddr | output | 32 | Head instruction byte address |
| qNextAddr | output | 16 | Head predicted successor |
| qTaken | output | 1 | Head predicted direction |
| fetchAddr | output | 16 | Current lookup address |

## Verification
A redirect can land in the same cycle as a push of a cached descriptor. The bench provokes this by restarting a fully cached chain while the consumer is not popping. It then raises a second redirect exactly when the lookup address sits on a further cached, non-full hit. The bench judges the result at the ports: the queue must be empty one cycle later, `fetchAddr` must equal the new target, and the first entry then drained must belong to the new target. A refill that is pending when a redirect arrives is the second overlap. It is judged by the refill request dropping and by no stale descriptor appearing in the queue.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;

  localparam int DESC_W   = 32;
  localparam int IP_W     = 12;
  localparam int OFF_W    = 10;
  localparam int KIND_LSB = 28;
  localparam int HINT_LSB = 22;
  localparam int OFF_LSB  = 12;

  localparam logic [1:0] HINT_NOTTAKEN = 2'b01;
  localparam logic [1:0] HINT_TAKEN    = 2'b10;

  typedef enum logic [3:0] {
    BK_FALL = 4'd0,
    BK_JUMP = 4'd1,
    BK_JREG = 4'd2,
    BK_FWD  = 4'd3,
    BK_BACK = 4'd4,
    BK_CALL = 4'd5,
    BK_RET  = 4'd6
  } blkKind_e;

  typedef struct packed {
    logic push;
    logic flush;
    logic advance;
    logic redirect;
    logic fill;
    logic rasPush;
    logic rasPop;
  } ctrlStb_t;

endpackage

// File: rtl/desc_fetch_queue.sv
module desc_fetch_queue #(
  parameter int W     = 81,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         push,
  input  logic [W-1:0]                 pushData,
  input  logic                         pop,
  input  logic                         flush,
  output logic                         valid,
  output logic                         full,
  output logic [W-1:0]                 headData,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  slotQ [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cntQ;
  logic          doPush, doPop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush = push && !flush && (cntQ != CW'(DEPTH));
  assign doPop  = pop && !flush && (cntQ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cntQ  <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cntQ  <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      if (doPush && !doPop)      cntQ <= cntQ + 1'b1;
      else if (doPop && !doPush) cntQ <= cntQ - 1'b1;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (doPush && wrPtr == PW'(s)) slotQ[s] <= pushData;
    end
  end

  assign headData = slotQ[rdPtr];
  assign valid    = (cntQ != '0);
  assign full     = (cntQ == CW'(DEPTH));
  assign count    = cntQ;

endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl
  import desc_fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        redirectValid,
  input  logic        lkHit,
  input  logic [3:0]  lkKind,
  input  logic        qFull,
  input  logic        jrValid,
  input  logic        refillValid,
  output ctrlStb_t    stb,
  output logic        refillReq
);
  typedef enum logic {ST_LOOK = 1'b0, ST_MISS = 1'b1} ctrlState_e;

  ctrlState_e stateQ, stateD;
  logic       jrStall;

  assign jrStall = (lkKind == BK_JREG) && !jrValid;

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_LOOK: begin
        if (redirectValid) begin
          stb.flush    = 1'b1;
          stb.redirect = 1'b1;
        end else if (!lkHit) begin
          stateD = ST_MISS;
        end else if (!qFull && !jrStall) begin
          stb.push    = 1'b1;
          stb.advance = 1'b1;
          stb.rasPush = (lkKind == BK_CALL);
          stb.rasPop  = (lkKind == BK_RET);
        end
      end
      ST_MISS: begin
        if (redirectValid) begin
          stb.flush    = 1'b1;
          stb.redirect = 1'b1;
          stateD       = ST_LOOK;
        end else if (refillValid) begin
          stb.fill = 1'b1;
          stateD   = ST_LOOK;
        end
      end
      default: stateD = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_LOOK;
    else       stateQ <= stateD;
  end

  assign refillReq = (stateQ == ST_MISS);

endmodule

// File: rtl/desc_fetch_dp.sv
module desc_fetch_dp
  import desc_fetch_pkg::*;
#(
  parameter int DA_W   = 16,
  parameter int IDX_W  = 5,
  parameter int PHT_W  = 4,
  parameter int RAS_D  = 4,
  parameter int PAGE_W = 18,
  parameter logic [DA_W-1:0] RESET_ADDR = '0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStb_t                      stb,
  input  logic [DA_W-1:0]               redirectAddr,
  input  logic [PAGE_W-1:0]             pageBase,
  input  logic [DESC_W-1:0]             refillData,
  input  logic [DA_W-1:0]               jrTarget,
  input  logic                          updValid,
  input  logic [DA_W-1:0]               updAddr,
  input  logic                          updTaken,
  output logic [DA_W-1:0]               curAddr,
  output logic                          lkHit,
  output logic [3:0]                    lkKind,
  output logic [DESC_W-1:0]             lkDesc,
  output logic [PAGE_W+IP_W+1:0]        lkInst,
  output logic [DA_W-1:0]               lkNext,
  output logic                          lkTaken
);
  localparam int SETS   = 1 << IDX_W;
  localparam int TAG_W  = DA_W - IDX_W;
  localparam int PHT_N  = 1 << PHT_W;
  localparam int RAS_PW = (RAS_D > 1) ? $clog2(RAS_D) : 1;
  localparam int IA_W   = PAGE_W + IP_W + 2;

  logic [DA_W-1:0]   pcQ;
  logic              vldQ  [SETS];
  logic [TAG_W-1:0]  tagQ  [SETS];
  logic [DESC_W-1:0] descQ [SETS];
  logic [IA_W-1:0]   instQ [SETS];
  logic [DA_W-1:0]   tgtQ  [SETS];
  logic [1:0]        phtQ  [PHT_N];
  logic [DA_W-1:0]   rasQ  [RAS_D];
  logic [RAS_PW-1:0] rasPtr, rasTopIdx;

  logic [IDX_W-1:0]  setIdx;
  logic [TAG_W-1:0]  setTag;
  logic [1:0]        hint;
  logic [1:0]        ctr;
  logic [DA_W-1:0]   seqAddr, fillTgt, rasTop;

  assign setIdx    = pcQ[IDX_W-1:0];
  assign setTag    = pcQ[DA_W-1:IDX_W];
  assign lkHit     = vldQ[setIdx] && (tagQ[setIdx] == setTag);
  assign lkDesc    = descQ[setIdx];
  assign lkInst    = instQ[setIdx];
  assign lkKind    = lkDesc[KIND_LSB +: 4];
  assign hint      = lkDesc[HINT_LSB +: 2];
  assign ctr       = phtQ[pcQ[PHT_W-1:0]];
  assign seqAddr   = pcQ + 1'b1;
  assign rasTopIdx = rasPtr - 1'b1;
  assign rasTop    = rasQ[rasTopIdx];
  assign fillTgt   = pcQ + {{(DA_W-OFF_W){refillData[OFF_LSB+OFF_W-1]}},
                            refillData[OFF_LSB +: OFF_W]};
  assign curAddr   = pcQ;

  // successor selection per block kind
  always_comb begin
    lkTaken = 1'b0;
    lkNext  = seqAddr;
    unique case (lkKind)
      BK_JUMP, BK_CALL: lkNext = tgtQ[setIdx];
      BK_FWD, BK_BACK: begin
        if (hint == HINT_TAKEN)         lkTaken = 1'b1;
        else if (hint == HINT_NOTTAKEN) lkTaken = 1'b0;
        else                            lkTaken = ctr[1];
        lkNext = lkTaken ? tgtQ[setIdx] : seqAddr;
      end
      BK_RET:  lkNext = rasTop;
      BK_JREG: lkNext = jrTarget;
      default: lkNext = seqAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pcQ <= RESET_ADDR;
    else if (stb.redirect) pcQ <= redirectAddr;
    else if (stb.advance)  pcQ <= lkNext;
  end

  // descriptor cache: tag state reset, payload written on refill
  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vldQ[s] <= 1'b0;
        tagQ[s] <= '0;
      end else if (stb.fill && setIdx == IDX_W'(s)) begin
        vldQ[s] <= 1'b1;
        tagQ[s] <= setTag;
      end
    end
    always_ff @(posedge clk) begin
      if (stb.fill && setIdx == IDX_W'(s)) begin
        descQ[s] <= refillData;
        instQ[s] <= {pageBase, refillData[IP_W-1:0], 2'b00};
        tgtQ[s]  <= fillTgt;
      end
    end
  end

  // direction counters, trained only through the update port
  for (genvar p = 0; p < PHT_N; p++) begin : g_pht
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phtQ[p] <= 2'b01;
      end else if (updValid && updAddr[PHT_W-1:0] == PHT_W'(p)) begin
        if (updTaken && phtQ[p] != 2'b11)       phtQ[p] <= phtQ[p] + 1'b1;
        else if (!updTaken && phtQ[p] != 2'b00) phtQ[p] <= phtQ[p] - 1'b1;
      end
    end
  end

  // return stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rasPtr <= '0;
    else if (stb.rasPush) rasPtr <= rasPtr + 1'b1;
    else if (stb.rasPop)  rasPtr <= rasTopIdx;
  end

  for (genvar r = 0; r < RAS_D; r++) begin : g_ras
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         rasQ[r] <= '0;
      else if (stb.rasPush && rasPtr == RAS_PW'(r))      rasQ[r] <= seqAddr;
    end
  end

endmodule

// File: rtl/desc_fetch_stage.sv
module desc_fetch_stage
  import desc_fetch_pkg::*;
#(
  parameter int DA_W    = 16,
  parameter int IDX_W   = 5,
  parameter int PHT_W   = 4,
  parameter int RAS_D   = 4,
  parameter int PAGE_W  = 18,
  parameter int Q_DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PAGE_W-1:0]       pageBase,
  input  logic                    redirectValid,
  input  logic [DA_W-1:0]         redirectAddr,
  input  logic                    jrValid,
  input  logic [DA_W-1:0]         jrTarget,
  input  logic                    updValid,
  input  logic [DA_W-1:0]         updAddr,
  input  logic                    updTaken,
  output logic                    refillReq,
  output logic [DA_W-1:0]         refillAddr,
  input  logic                    refillValid,
  input  logic [31:0]             refillData,
  output logic                    qValid,
  input  logic                    qReady,
  output logic [31:0]             qDesc,
  output logic [PAGE_W+IP_W+1:0]  qInstAddr,
  output logic [DA_W-1:0]         qNextAddr,
  output logic                    qTaken,
  output logic [DA_W-1:0]         fetchAddr
);
  localparam int IA_W  = PAGE_W + IP_W + 2;
  localparam int ENT_W = DESC_W + IA_W + DA_W + 1;
  localparam int CW    = $clog2(Q_DEPTH+1);

  ctrlStb_t          stb;
  logic              lkHit, lkTaken, qFull;
  logic [3:0]        lkKind;
  logic [DESC_W-1:0] lkDesc;
  logic [IA_W-1:0]   lkInst;
  logic [DA_W-1:0]   lkNext, curAddr;
  logic [ENT_W-1:0]  headData;
  logic [CW-1:0]     qCount;

  desc_fetch_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .redirectValid(redirectValid),
    .lkHit(lkHit), .lkKind(lkKind), .qFull(qFull), .jrValid(jrValid),
    .refillValid(refillValid), .stb(stb), .refillReq(refillReq)
  );

  desc_fetch_dp #(
    .DA_W(DA_W), .IDX_W(IDX_W), .PHT_W(PHT_W), .RAS_D(RAS_D), .PAGE_W(PAGE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .redirectAddr(redirectAddr),
    .pageBase(pageBase), .refillData(refillData), .jrTarget(jrTarget),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken),
    .curAddr(curAddr), .lkHit(lkHit), .lkKind(lkKind), .lkDesc(lkDesc),
    .lkInst(lkInst), .lkNext(lkNext), .lkTaken(lkTaken)
  );

  desc_fetch_queue #(.W(ENT_W), .DEPTH(Q_DEPTH)) i_queue (
    .clk(clk), .rstN(rstN), .push(stb.push),
    .pushData({lkDesc, lkInst, lkNext, lkTaken}),
    .pop(qReady), .flush(stb.flush), .valid(qValid), .full(qFull),
    .headData(headData), .count(qCount)
  );

  assign {qDesc, qInstAddr, qNextAddr, qTaken} = headData;
  assign fetchAddr  = curAddr;
  assign refillAddr = curAddr;

endmodule

// File: rtl/desc_fetch_sva.sv
module desc_fetch_sva
  import desc_fetch_pkg::*;
#(
  parameter int DA_W  = 16,
  parameter int DEPTH = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        redirectValid,
  input logic [DA_W-1:0]             redirectAddr,
  input logic                        refillReq,
  input logic                        refillValid,
  input logic [DA_W-1:0]             refillAddr,
  input logic                        jrValid,
  input logic [DA_W-1:0]             fetchAddr,
  input logic [$clog2(DEPTH+1)-1:0]  qCount,
  input ctrlStb_t                    stb,
  input logic [3:0]                  lkKind
);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= ($clog2(DEPTH+1))'(DEPTH));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == ($clog2(DEPTH+1))'(DEPTH) && !redirectValid) |=> $stable(fetchAddr));

  // R10
  flush_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (qCount == '0 && fetchAddr == $past(redirectAddr)));

  // R7
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refillReq && !refillValid && !redirectValid) |=> (refillReq && $stable(refillAddr)));

  // R7
  miss_nopush_chk: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> !stb.push);

  // R8
  jreg_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.push && lkKind == BK_JREG) |-> jrValid);

endmodule

bind desc_fetch_stage desc_fetch_sva #(.DA_W(DA_W), .DEPTH(Q_DEPTH)) i_sva (
  .clk(clk), .rstN(rstN), .redirectValid(redirectValid), .redirectAddr(redirectAddr),
  .refillReq(refillReq), .refillValid(refillValid), .refillAddr(refillAddr),
  .jrValid(jrValid), .fetchAddr(fetchAddr), .qCount(qCount), .stb(stb), .lkKind(lkKind)
);

// File: tb/test_desc_fetch_stage.sv
module test_desc_fetch_stage;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] pageBase = '0;
  logic        redirectValid = 1'b0;
  logic [15:0] redirectAddr = '0;
  logic        jrValid = 1'b0;
  logic [15:0] jrTarget = '0;
  logic        updValid = 1'b0;
  logic [15:0] updAddr = '0;
  logic        updTaken = 1'b0;
  logic        refillReq;
  logic [15:0] refillAddr;
  logic        refillValid = 1'b0;
  logic [31:0] refillData = '0;
  logic        qValid;
  logic        qReady = 1'b1;
  logic [31:0] qDesc;
  logic [31:0] qInstAddr;
  logic [15:0] qNextAddr;
  logic        qTaken;
  logic [15:0] fetchAddr;

  always #5 clk = ~clk;

  desc_fetch_stage i_desc_fetch_stage (
    .clk(clk), .rstN(rstN), .pageBase(pageBase),
    .redirectValid(redirectValid), .redirectAddr(redirectAddr),
    .jrValid(jrValid), .jrTarget(jrTarget),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken),
    .refillReq(refillReq), .refillAddr(refillAddr),
    .refillValid(refillValid), .refillData(refillData),
    .qValid(qValid), .qReady(qReady), .qDesc(qDesc), .qInstAddr(qInstAddr),
    .qNextAddr(qNextAddr), .qTaken(qTaken), .fetchAddr(fetchAddr)
  );

  localparam logic [17:0] P1 = 18'h12345;
  localparam logic [17:0] P2 = 18'h2ABCD;

  typedef struct {
    logic [31:0] d;
    logic [31:0] ia;
    logic [15:0] nx;
    logic        tk;
    string       rq;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] mem [logic [15:0]];
  int          errs = 0;
  int          checks = 0;

  function automatic logic [31:0] mkDesc(input logic [3:0] k, input logic [1:0] h,
                                         input int off, input logic [15:0] a);
    logic [9:0]  o;
    logic [11:0] ip;
    o  = off[9:0];
    ip = a[11:0] ^ 12'hC3A;
    return {k, 4'd5, h, o, ip};
  endfunction

  function automatic logic [31:0] instOf(input logic [17:0] pg, input logic [31:0] d);
    return {pg, d[11:0], 2'b00};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic expectAt(input logic [15:0] a, input logic [17:0] pg,
                          input logic [15:0] nx, input logic tk, input string rq);
    exp_t e;
    e.d = mem[a]; e.ia = instOf(pg, mem[a]); e.nx = nx; e.tk = tk; e.rq = rq;
    expQ.push_back(e);
  endtask

  // monitor: pops expected entries as the queue drains
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN && qValid && qReady) begin
        if (expQ.size() == 0) begin
          checks++;
          errs++;
          $display("FAIL R9 extra entry act=%0h exp=none", qNextAddr);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(qDesc == e.d && qInstAddr == e.ia && qNextAddr == e.nx && qTaken == e.tk,
                e.rq, "entry{desc,inst,next,tk}",
                {qDesc[15:0], qInstAddr[15:0], qNextAddr, 15'd0, qTaken},
                {e.d[15:0], e.ia[15:0], e.nx, 15'd0, e.tk});
        end
      end
    end
  end

  // refill responder, two cycles of latency
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && refillReq) begin
        repeat (2) @(negedge clk);
        if (refillReq) begin
          refillData  = mem.exists(refillAddr) ? mem[refillAddr] : {4'd2, 28'd0};
          refillValid = 1'b1;
          @(negedge clk);
          refillValid = 1'b0;
        end
      end
    end
  end

  task automatic redirect(input logic [15:0] a);
    @(negedge clk);
    redirectValid = 1'b1;
    redirectAddr  = a;
    @(negedge clk);
    redirectValid = 1'b0;
  endtask

  task automatic train(input logic [15:0] a, input logic tk);
    @(negedge clk);
    updValid = 1'b1; updAddr = a; updTaken = tk;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic drain(input string rq);
    int n = 0;
    while (expQ.size() != 0 && n < 600) begin
      @(negedge clk);
      n++;
    end
    check(expQ.size() == 0, rq, "entries left", 64'(expQ.size()), 64'd0);
    expQ.delete();
    repeat (15) @(negedge clk);
  endtask

  task automatic loadPrograms();
    mem[16'h0000] = mkDesc(4'd2, 2'b00, 0, 16'h0000);
    // region 1: mixed kinds
    mem[16'h0100] = mkDesc(4'd0, 2'b00, 0, 16'h0100);
    mem[16'h0101] = mkDesc(4'd1, 2'b00, 4, 16'h0101);
    mem[16'h0105] = mkDesc(4'd5, 2'b00, 10, 16'h0105);
    mem[16'h010F] = mkDesc(4'd0, 2'b00, 0, 16'h010F);
    mem[16'h0110] = mkDesc(4'd6, 2'b00, 0, 16'h0110);
    mem[16'h0106] = mkDesc(4'd3, 2'b10, 3, 16'h0106);
    mem[16'h0109] = mkDesc(4'd4, 2'b01, -2, 16'h0109);
    mem[16'h010A] = mkDesc(4'd2, 2'b00, 0, 16'h010A);
    // region 2: dynamic direction
    mem[16'h0200] = mkDesc(4'd0, 2'b00, 0, 16'h0200);
    mem[16'h0201] = mkDesc(4'd3, 2'b00, 5, 16'h0201);
    mem[16'h0202] = mkDesc(4'd1, 2'b00, 1, 16'h0202);
    mem[16'h0203] = mkDesc(4'd3, 2'b11, 4, 16'h0203);
    mem[16'h0207] = mkDesc(4'd4, 2'b01, -5, 16'h0207);
    mem[16'h0208] = mkDesc(4'd0, 2'b00, 0, 16'h0208);
    mem[16'h0209] = mkDesc(4'd2, 2'b00, 0, 16'h0209);
    // region 3: indirect jump
    mem[16'h0300] = mkDesc(4'd2, 2'b00, 0, 16'h0300);
    mem[16'h0310] = mkDesc(4'd0, 2'b00, 0, 16'h0310);
    mem[16'h0311] = mkDesc(4'd2, 2'b00, 0, 16'h0311);
    // region 4: straight chain
    for (int k = 0; k < 12; k++) mem[16'h0400 + 16'(k)] = mkDesc(4'd0, 2'b00, 0, 16'h0400 + 16'(k));
    mem[16'h040C] = mkDesc(4'd2, 2'b00, 0, 16'h040C);
  endtask

  task automatic expectRegion1(input logic [17:0] pg, input string rq);
    expectAt(16'h0100, pg, 16'h0101, 1'b0, rq);
    expectAt(16'h0101, pg, 16'h0105, 1'b0, rq);
    expectAt(16'h0105, pg, 16'h010F, 1'b0, rq);
    expectAt(16'h010F, pg, 16'h0110, 1'b0, rq);
    expectAt(16'h0110, pg, 16'h0106, 1'b0, rq);
    expectAt(16'h0106, pg, 16'h0109, 1'b1, rq);
    expectAt(16'h0109, pg, 16'h010A, 1'b0, rq);
  endtask

  task automatic runAll();
    loadPrograms();
    pageBase = P1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(qValid == 1'b0, "R1", "qValid after reset", 64'(qValid), 64'd0);
    check(fetchAddr == 16'h0000, "R1", "fetchAddr after reset", 64'(fetchAddr), 64'd0);
    repeat (12) @(negedge clk);

    // R2 R3 R4 R6 R7: mixed block kinds with refills
    expectRegion1(P1, "R2/R3/R4");
    redirect(16'h0100);
    @(negedge clk);
    check(refillReq && refillAddr == 16'h0100, "R7", "refill request address",
          {47'd0, refillReq, refillAddr}, {47'd1, 16'h0100});
    drain("R2");
    check(fetchAddr == 16'h010A && !refillReq, "R8", "parked at indirect jump",
          64'(fetchAddr), 64'h010A);

    // R6: cached lines keep the page base seen at refill
    pageBase = P2;
    expectRegion1(P1, "R6");
    redirect(16'h0100);
    drain("R6");

    // R4 R5: trained counters
    train(16'h0203, 1'b1);
    train(16'h0207, 1'b1);
    train(16'h0207, 1'b1);
    train(16'h0208, 1'b1);
    train(16'h0208, 1'b1);
    train(16'h0202, 1'b1);
    train(16'h0202, 1'b1);
    expectAt(16'h0200, P2, 16'h0201, 1'b0, "R5");
    expectAt(16'h0201, P2, 16'h0202, 1'b0, "R4");
    expectAt(16'h0202, P2, 16'h0203, 1'b0, "R5");
    expectAt(16'h0203, P2, 16'h0207, 1'b1, "R4");
    expectAt(16'h0207, P2, 16'h0208, 1'b0, "R4");
    expectAt(16'h0208, P2, 16'h0209, 1'b0, "R5");
    redirect(16'h0200);
    drain("R4");

    // R8: indirect jump waits for the back end
    expectAt(16'h0300, P2, 16'h0310, 1'b0, "R8");
    expectAt(16'h0310, P2, 16'h0311, 1'b0, "R8");
    redirect(16'h0300);
    repeat (15) @(negedge clk);
    check(!qValid && fetchAddr == 16'h0300, "R8", "stall before target",
          {qValid, 15'd0, fetchAddr}, {1'b0, 15'd0, 16'h0300});
    jrTarget = 16'h0310;
    jrValid  = 1'b1;
    begin
      int n = 0;
      while (expQ.size() > 1 && n < 100) begin
        @(negedge clk);
        n++;
      end
    end
    jrValid = 1'b0;
    drain("R8");

    // R9: full queue holds lookup and loses nothing
    qReady = 1'b0;
    for (int k = 0; k < 12; k++)
      expectAt(16'h0400 + 16'(k), P2, 16'h0401 + 16'(k), 1'b0, "R9");
    redirect(16'h0400);
    repeat (100) @(negedge clk);
    check(fetchAddr == 16'h0408 && qValid && !refillReq, "R9", "full stall address",
          64'(fetchAddr), 64'h0408);
    qReady = 1'b1;
    drain("R9");

    // R10: redirect in the same cycle as a push of a cached hit
    qReady = 1'b0;
    redirect(16'h0400);
    repeat (3) @(negedge clk);
    check(qValid && fetchAddr == 16'h0403, "R10", "pushing before flush",
          64'(fetchAddr), 64'h0403);
    redirect(16'h0310);
    check(!qValid && fetchAddr == 16'h0310, "R10", "flush wins over push",
          {qValid, 15'd0, fetchAddr}, {1'b0, 15'd0, 16'h0310});
    expectAt(16'h0310, P2, 16'h0311, 1'b0, "R10");
    qReady = 1'b1;
    drain("R10");

    // R10: redirect cancels a pending refill
    redirect(16'h0500);
    @(negedge clk);
    check(refillReq && refillAddr == 16'h0500, "R10", "miss before cancel",
          64'(refillAddr), 64'h0500);
    redirect(16'h0311);
    check(!refillReq && fetchAddr == 16'h0311, "R10", "refill cancelled",
          {refillReq, 15'd0, fetchAddr}, {1'b0, 15'd0, 16'h0311});
    repeat (20) @(negedge clk);
    check(!qValid, "R10", "no stale entry", 64'(qValid), 64'd0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule